// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is the control unit of a small multicycle accumulator processor. A nine-state synchronous machine steps through two fetch states (F0, F1), four address-evaluation states (AD0 to AD3) and three execution states (EX0 to EX2). The path through the address and execution states depends on the current opcode and addressing mode. In every cycle it drives a 17-bit word of control strobes to the datapath. There are seven instructions: jump, subroutine jump with return-address store, store accumulator, increment-and-skip-if-zero, load accumulator, AND and ADD. There are three addressing modes: direct, indirect and indexed.

The control word is produced combinationally from the registered state and the live opcode and mode inputs. It is therefore valid in the same cycle that the state and inputs are present. Opcode and mode codes that are undefined, and opcodes that have no meaning in the current state, abort the instruction. In that cycle every strobe is zero, and the next state is F0. A parameter selects binary or one-hot state encoding. The encoding does not change behaviour at the ports.

Top module: `acc_ctl_fsm`

## Requirements
- R1: An active-low `rst_n` forces state F0 at once, without waiting for a clock edge. The F0 control word is visible while reset is held. After `rst_n` rises, the machine stays in F0 for two more rising edges and leaves F0 on the third.
- R2: F0 always advances to F1, and F1 always advances to AD0, whatever the opcode and mode. F0 drives bits 0 (PC to address register) and 1 (memory read). F1 drives bits 2 (load instruction register) and 3 (PC increment).
- R3: Opcode codes: 0 jump, 1 subroutine jump, 2 store acc, 3 inc-skip, 4 load, 5 AND, 6 ADD, 7 undefined. Mode codes: 0 direct, 1 indirect, 2 indexed, 3 undefined. AD0 routing:
  - Indirect goes to AD1.
  - Direct: jump goes to F0, subroutine jump goes to AD2, all other opcodes go to AD3.
  - Indexed: jump goes to F0, subroutine jump goes to AD1, all other opcodes go to AD2.
- R4: AD0 drives:
  - bit 4 (instruction address to address register), always;
  - bit 5 (index add) in indexed mode, except for subroutine jump;
  - bit 1 in indirect mode;
  - bit 7 (load PC) for a jump that is not indirect.
- R5: AD1 always goes to AD2. It drives bit 1 in indirect mode and bit 5 otherwise.
- R6: AD2 sends a jump to F0 and every other opcode to AD3. It drives bit 6 (data register to address register) in indirect mode and bit 7 for a jump.
- R7: AD3 routing and outputs:
  - Subroutine jump drives bits 7, 8 (PC to data register) and 9 (memory write), then goes to F0.
  - Store acc drives bits 9 and 10 (acc to data register), then goes to F0.
  - Inc-skip, load, AND and ADD drive bit 1 and go to EX0.
- R8: EX0 routing and outputs:
  - Load drives bits 11 (data register to acc) and 16 (acc write).
  - AND drives bits 12 and 16.
  - ADD drives bits 13 and 16.
  - Load, AND and ADD all return to F0.
  - Inc-skip drives bit 14 (data increment) and goes to EX1.
- R9: EX1 drives bit 9 and goes to EX2. EX2 drives bit 15 (skip if zero) and goes to F0.
- R10: In any state other than F0 and F1, opcode 7 or mode 3 makes all 17 bits zero in that cycle and sends the machine to F0 next.
- R11: A jump in AD3, or a jump, subroutine jump or store acc in EX0, makes all 17 bits zero in that cycle and sends the machine to F0 next.
- R12: A change of opcode or mode within a state shows on the control word in the same cycle, with no clock edge needed.
- R13: Binary and one-hot state encodings give identical control words at every cycle for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode | input | 3 | Opcode of the current instruction |
| amode | input | 2 | Addressing mode of the current instruction |
| ctrl | output | 17 | Control strobes to the datapath |

## Verification
The control word depends on the state register and on the inputs combinationally. A stimulus applied inside a state is therefore checked 1 ns later in that same cycle, and a state move is checked at the falling edge that follows the next rising edge. Each path is walked one falling edge per state, and the return to F0 is checked at the falling edge after the last state of the path. After reset is released, the checks expect F0 to persist through two rising edges, because of the synchronising stages. An asynchronous assertion of reset in the middle of an instruction is checked before any edge occurs.

// File: rtl/acc_ctl_pkg.sv
package acc_ctl_pkg;

  localparam int OP_W       = 3;
  localparam int MODE_W     = 2;
  localparam int CTRL_W     = 17;
  localparam int NUM_STATES = 9;
  localparam int ST_W       = $clog2(NUM_STATES);

  typedef enum logic [ST_W-1:0] {
    ST_F0  = 4'd0,
    ST_F1  = 4'd1,
    ST_AD0 = 4'd2,
    ST_AD1 = 4'd3,
    ST_AD2 = 4'd4,
    ST_AD3 = 4'd5,
    ST_EX0 = 4'd6,
    ST_EX1 = 4'd7,
    ST_EX2 = 4'd8
  } ctl_state_e;

  typedef enum logic [OP_W-1:0] {
    OP_JMP = 3'd0,
    OP_JSR = 3'd1,
    OP_STA = 3'd2,
    OP_INZ = 3'd3,
    OP_LDA = 3'd4,
    OP_ANA = 3'd5,
    OP_ADA = 3'd6,
    OP_RSV = 3'd7
  } opcode_e;

  typedef enum logic [MODE_W-1:0] {
    AM_DIR = 2'd0,
    AM_IND = 2'd1,
    AM_IDX = 2'd2,
    AM_RSV = 2'd3
  } amode_e;

  // control word bit positions
  localparam int CB_PC2AR   = 0;
  localparam int CB_MRD     = 1;
  localparam int CB_LDIR    = 2;
  localparam int CB_PCINC   = 3;
  localparam int CB_IRA2AR  = 4;
  localparam int CB_IDXADD  = 5;
  localparam int CB_DR2AR   = 6;
  localparam int CB_LDPC    = 7;
  localparam int CB_PC2DR   = 8;
  localparam int CB_MWR     = 9;
  localparam int CB_ACC2DR  = 10;
  localparam int CB_DR2ACC  = 11;
  localparam int CB_ALUAND  = 12;
  localparam int CB_ALUADD  = 13;
  localparam int CB_DRINC   = 14;
  localparam int CB_SKIPZ   = 15;
  localparam int CB_ACCWR   = 16;

endpackage

// File: rtl/acc_ctl_rstsync.sv
module acc_ctl_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_ctl_streg.sv
module acc_ctl_streg
  import acc_ctl_pkg::*;
#(
  parameter bit ONEHOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_state_e nxt_i,
  output ctl_state_e cur_o
);

  localparam int SW = ONEHOT ? NUM_STATES : ST_W;

  logic [SW-1:0] st_d;
  logic [SW-1:0] st_q;

  generate
    if (ONEHOT) begin : g_onehot
      localparam logic [SW-1:0] RST_VAL = SW'(1) << int'(ST_F0);

      always_comb begin
        st_d = '0;
        st_d[int'(nxt_i)] = 1'b1;
      end

      always_comb begin
        cur_o = ST_F0;
        for (int i = 0; i < NUM_STATES; i++) begin
          if (st_q[i]) cur_o = ctl_state_e'(ST_W'(i));
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
      end

      assert_state_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q) == 1)
        else $error("one-hot state register lost its single set bit");
    end else begin : g_binary
      localparam logic [SW-1:0] RST_VAL = SW'(ST_F0);

      always_comb st_d  = SW'(nxt_i);
      always_comb cur_o = ctl_state_e'(st_q);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
      end

      assert_state_in_range_R13: assert property (@(posedge clk) disable iff (!rst_n)
        st_q < SW'(NUM_STATES))
        else $error("binary state register holds an unused code");
    end
  endgenerate

endmodule

// File: rtl/acc_ctl_next.sv
module acc_ctl_next
  import acc_ctl_pkg::*;
(
  input  ctl_state_e cur_i,
  input  opcode_e    op_i,
  input  amode_e     md_i,
  output ctl_state_e nxt_o
);

  logic undef;
  logic is_data;

  always_comb begin
    undef   = (op_i == OP_RSV) || (md_i == AM_RSV);
    is_data = (op_i == OP_INZ) || (op_i == OP_LDA) ||
              (op_i == OP_ANA) || (op_i == OP_ADA);
    nxt_o   = ST_F0;
    case (cur_i)
      ST_F0: nxt_o = ST_F1;
      ST_F1: nxt_o = ST_AD0;
      ST_AD0: begin
        if (undef) begin
          nxt_o = ST_F0;
        end else begin
          case (md_i)
            AM_IND: nxt_o = ST_AD1;
            AM_DIR: begin
              if (op_i == OP_JMP)      nxt_o = ST_F0;
              else if (op_i == OP_JSR) nxt_o = ST_AD2;
              else                     nxt_o = ST_AD3;
            end
            AM_IDX: begin
              if (op_i == OP_JMP)      nxt_o = ST_F0;
              else if (op_i == OP_JSR) nxt_o = ST_AD1;
              else                     nxt_o = ST_AD2;
            end
            default: nxt_o = ST_F0;
          endcase
        end
      end
      ST_AD1: nxt_o = undef ? ST_F0 : ST_AD2;
      ST_AD2: nxt_o = (undef || op_i == OP_JMP) ? ST_F0 : ST_AD3;
      ST_AD3: nxt_o = (!undef && is_data) ? ST_EX0 : ST_F0;
      ST_EX0: nxt_o = (!undef && op_i == OP_INZ) ? ST_EX1 : ST_F0;
      ST_EX1: nxt_o = undef ? ST_F0 : ST_EX2;
      ST_EX2: nxt_o = ST_F0;
      default: nxt_o = ST_F0;
    endcase
  end

endmodule

// File: rtl/acc_ctl_out.sv
module acc_ctl_out
  import acc_ctl_pkg::*;
(
  input  ctl_state_e        cur_i,
  input  opcode_e           op_i,
  input  amode_e            md_i,
  output logic [CTRL_W-1:0] ctrl_o
);

  logic in_fetch;
  logic bad_code;
  logic [CTRL_W-1:0] word;

  always_comb begin
    word = '0;
    case (cur_i)
      ST_F0: begin
        word[CB_PC2AR] = 1'b1;
        word[CB_MRD]   = 1'b1;
      end
      ST_F1: begin
        word[CB_LDIR]  = 1'b1;
        word[CB_PCINC] = 1'b1;
      end
      ST_AD0: begin
        word[CB_IRA2AR] = 1'b1;
        word[CB_IDXADD] = (md_i == AM_IDX) && (op_i != OP_JSR);
        word[CB_MRD]    = (md_i == AM_IND);
        word[CB_LDPC]   = (op_i == OP_JMP) && (md_i != AM_IND);
      end
      ST_AD1: begin
        if (md_i == AM_IND) word[CB_MRD]    = 1'b1;
        else                word[CB_IDXADD] = 1'b1;
      end
      ST_AD2: begin
        word[CB_DR2AR] = (md_i == AM_IND);
        word[CB_LDPC]  = (op_i == OP_JMP);
      end
      ST_AD3: begin
        case (op_i)
          OP_JSR: begin
            word[CB_LDPC]  = 1'b1;
            word[CB_PC2DR] = 1'b1;
            word[CB_MWR]   = 1'b1;
          end
          OP_STA: begin
            word[CB_ACC2DR] = 1'b1;
            word[CB_MWR]    = 1'b1;
          end
          OP_INZ, OP_LDA, OP_ANA, OP_ADA: word[CB_MRD] = 1'b1;
          default: word = '0;
        endcase
      end
      ST_EX0: begin
        case (op_i)
          OP_LDA: begin
            word[CB_DR2ACC] = 1'b1;
            word[CB_ACCWR]  = 1'b1;
          end
          OP_ANA: begin
            word[CB_ALUAND] = 1'b1;
            word[CB_ACCWR]  = 1'b1;
          end
          OP_ADA: begin
            word[CB_ALUADD] = 1'b1;
            word[CB_ACCWR]  = 1'b1;
          end
          OP_INZ: word[CB_DRINC] = 1'b1;
          default: word = '0;
        endcase
      end
      ST_EX1: word[CB_MWR]   = 1'b1;
      ST_EX2: word[CB_SKIPZ] = 1'b1;
      default: word = '0;
    endcase
  end

  always_comb begin
    in_fetch = (cur_i == ST_F0) || (cur_i == ST_F1);
    bad_code = (op_i == OP_RSV) || (md_i == AM_RSV);
    ctrl_o   = (!in_fetch && bad_code) ? '0 : word;
  end

endmodule

// File: rtl/acc_ctl_fsm.sv
module acc_ctl_fsm
  import acc_ctl_pkg::*;
#(
  parameter bit STATE_ONEHOT = 1'b0,
  parameter int RST_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode,
  input  logic [MODE_W-1:0] amode,
  output logic [CTRL_W-1:0] ctrl
);

  logic       core_rst_n;
  ctl_state_e cur;
  ctl_state_e nxt;
  opcode_e    op;
  amode_e     md;

  assign op = opcode_e'(opcode);
  assign md = amode_e'(amode);

  acc_ctl_rstsync #(.STAGES(RST_STAGES)) u_rstsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  acc_ctl_next u_next (
    .cur_i (cur),
    .op_i  (op),
    .md_i  (md),
    .nxt_o (nxt)
  );

  acc_ctl_streg #(.ONEHOT(STATE_ONEHOT)) u_streg (
    .clk   (clk),
    .rst_n (core_rst_n),
    .nxt_i (nxt),
    .cur_o (cur)
  );

  acc_ctl_out u_out (
    .cur_i  (cur),
    .op_i   (op),
    .md_i   (md),
    .ctrl_o (ctrl)
  );

  assert_fetch_first_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cur == ST_F0) |=> (cur == ST_F1))
    else $error("first fetch state did not advance");

  assert_fetch_second_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cur == ST_F1) |=> (cur == ST_AD0))
    else $error("second fetch state did not enter address evaluation");

  assert_undef_quiet_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((cur != ST_F0) && (cur != ST_F1) && ((opcode == 3'd7) || (amode == 2'd3)))
      |-> (ctrl == '0))
    else $error("undefined code left strobes active");

  assert_undef_return_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((cur != ST_F0) && (cur != ST_F1) && ((opcode == 3'd7) || (amode == 2'd3)))
      |=> (cur == ST_F0))
    else $error("undefined code did not abort to fetch");

  assert_accwr_ends_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctrl[CB_ACCWR] |=> (cur == ST_F0))
    else $error("accumulator write not followed by fetch");

  assert_skip_chain_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctrl[CB_MWR] && (cur == ST_EX1) |=> (cur == ST_EX2))
    else $error("increment write-back not followed by skip state");

endmodule

// File: tb/acc_ctl_fsm_tb.sv
module acc_ctl_fsm_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 23;

  logic        clk;
  logic        rst_n;
  logic [2:0]  opcode;
  logic [1:0]  amode;
  logic [16:0] ctrl;
  logic [16:0] ctrl_oh;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  acc_ctl_fsm #(.STATE_ONEHOT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .amode(amode), .ctrl(ctrl)
  );

  acc_ctl_fsm #(.STATE_ONEHOT(1'b1)) u_dut_oh (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .amode(amode), .ctrl(ctrl_oh)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // entry: {opcode, mode, path length, path} ; path nibble k = k-th state
  // state codes: 0 F0, 1 F1, 2 AD0, 3 AD1, 4 AD2, 5 AD3, 6 EX0, 7 EX1, 8 EX2
  localparam logic [44:0] VECS [NVEC] = '{
    {3'd0, 2'd0, 4'd3, 36'h000000210},
    {3'd0, 2'd1, 4'd5, 36'h000043210},
    {3'd0, 2'd2, 4'd3, 36'h000000210},
    {3'd1, 2'd0, 4'd5, 36'h000054210},
    {3'd1, 2'd1, 4'd6, 36'h000543210},
    {3'd1, 2'd2, 4'd6, 36'h000543210},
    {3'd2, 2'd0, 4'd4, 36'h000005210},
    {3'd2, 2'd1, 4'd6, 36'h000543210},
    {3'd2, 2'd2, 4'd5, 36'h000054210},
    {3'd3, 2'd0, 4'd7, 36'h008765210},
    {3'd3, 2'd1, 4'd9, 36'h876543210},
    {3'd3, 2'd2, 4'd8, 36'h087654210},
    {3'd4, 2'd0, 4'd5, 36'h000065210},
    {3'd4, 2'd1, 4'd7, 36'h006543210},
    {3'd4, 2'd2, 4'd6, 36'h000654210},
    {3'd5, 2'd0, 4'd5, 36'h000065210},
    {3'd5, 2'd1, 4'd7, 36'h006543210},
    {3'd5, 2'd2, 4'd6, 36'h000654210},
    {3'd6, 2'd0, 4'd5, 36'h000065210},
    {3'd6, 2'd1, 4'd7, 36'h006543210},
    {3'd6, 2'd2, 4'd6, 36'h000654210},
    {3'd7, 2'd0, 4'd3, 36'h000000210},
    {3'd4, 2'd3, 4'd3, 36'h000000210}
  };

  function automatic logic [16:0] exp_ctrl(input int st, input int op, input int md);
    logic [16:0] w;
    w = '0;
    case (st)
      0: begin w[0] = 1'b1; w[1] = 1'b1; end
      1: begin w[2] = 1'b1; w[3] = 1'b1; end
      2: begin
        w[4] = 1'b1;
        if (md == 2 && op != 1) w[5] = 1'b1;
        if (md == 1)            w[1] = 1'b1;
        if (op == 0 && md != 1) w[7] = 1'b1;
      end
      3: if (md == 1) w[1] = 1'b1; else w[5] = 1'b1;
      4: begin
        if (md == 1) w[6] = 1'b1;
        if (op == 0) w[7] = 1'b1;
      end
      5: begin
        if (op == 1) begin w[7] = 1'b1; w[8] = 1'b1; w[9] = 1'b1; end
        else if (op == 2) begin w[9] = 1'b1; w[10] = 1'b1; end
        else if (op >= 3 && op <= 6) w[1] = 1'b1;
      end
      6: begin
        if (op == 4) begin w[11] = 1'b1; w[16] = 1'b1; end
        else if (op == 5) begin w[12] = 1'b1; w[16] = 1'b1; end
        else if (op == 6) begin w[13] = 1'b1; w[16] = 1'b1; end
        else if (op == 3) w[14] = 1'b1;
      end
      7: w[9]  = 1'b1;
      8: w[15] = 1'b1;
      default: w = '0;
    endcase
    if (st >= 2 && (op == 7 || md == 3)) w = '0;
    return w;
  endfunction

  function automatic string req_of(input int st, input int op, input int md);
    if (st >= 2 && (op == 7 || md == 3)) return "R10";
    case (st)
      0, 1:    return "R2";
      2:       return "R4";
      3:       return "R5";
      4:       return "R6";
      5:       return "R7";
      6:       return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string rq, input int st);
    logic [16:0] e;
    e = exp_ctrl(st, int'(opcode), int'(amode));
    n_vec++;
    if (ctrl !== e) begin
      n_bad++;
      $display("FAIL %s: op=%0d mode=%0d state=%0d ctrl actual=%05h expected=%05h",
               rq, opcode, amode, st, ctrl, e);
    end
    n_vec++;
    if (ctrl_oh !== e) begin
      n_bad++;
      $display("FAIL R13: one-hot variant op=%0d mode=%0d state=%0d actual=%05h expected=%05h",
               opcode, amode, st, ctrl_oh, e);
    end
  endtask

  task automatic step(input string rq, input int st);
    chk(rq, st);
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [44:0] v);
    int len;
    int last;
    opcode = v[44:42];
    amode  = v[41:40];
    len    = int'(v[39:36]);
    last   = 0;
    #1;
    for (int k = 0; k < len; k++) begin
      int st;
      st = int'(v[4*k +: 4]);
      step(req_of(st, int'(opcode), int'(amode)), st);
      last = st;
    end
    // return to first fetch state after the final state of the path
    case (last)
      2:       chk("R3", 0);
      4:       chk("R6", 0);
      5:       chk("R7", 0);
      6:       chk("R8", 0);
      default: chk("R9", 0);
    endcase
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b1;
    opcode = 3'd4;
    amode  = 2'd0;
    #1 rst_n = 1'b0;
    #3;
    chk("R1", 0);                      // reset visible before any edge
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 0);                      // first edge after release: still F0
    @(negedge clk);

    // table walk: every opcode and mode, plus undefined codes
    for (int i = 0; i < NVEC; i++) begin
      run_vec(VECS[i]);
    end

    // R12: mode change inside AD0 shows in the same cycle
    opcode = 3'd4; amode = 2'd0; #1;
    step("R2", 0);
    step("R2", 1);
    chk("R4", 2);
    amode = 2'd2; #1;
    chk("R12", 2);
    amode = 2'd0; #1;
    step("R12", 2);
    step("R7", 5);
    step("R8", 6);
    chk("R8", 0);

    // R11: jump presented in AD3
    opcode = 3'd4; amode = 2'd0; #1;
    step("R2", 0); step("R2", 1); step("R4", 2);
    opcode = 3'd0; #1;
    step("R11", 5);
    chk("R11", 0);

    // R11: store acc presented in EX0
    opcode = 3'd4; amode = 2'd0; #1;
    step("R2", 0); step("R2", 1); step("R4", 2); step("R7", 5);
    opcode = 3'd2; #1;
    step("R11", 6);
    chk("R11", 0);

    // R10: undefined opcode while in EX1
    opcode = 3'd3; amode = 2'd0; #1;
    step("R2", 0); step("R2", 1); step("R4", 2); step("R7", 5); step("R8", 6);
    opcode = 3'd7; #1;
    step("R10", 7);
    chk("R10", 0);

    // R10: undefined mode while in AD2
    opcode = 3'd4; amode = 2'd1; #1;
    step("R2", 0); step("R2", 1); step("R4", 2); step("R5", 3);
    amode = 2'd3; #1;
    step("R10", 4);
    chk("R10", 0);

    // R1: reset in mid-instruction acts without a clock edge
    opcode = 3'd3; amode = 2'd0; #1;
    step("R2", 0); step("R2", 1); step("R4", 2); step("R7", 5);
    rst_n = 1'b0; #1;
    chk("R1", 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 0);
    @(negedge clk);
    step("R1", 0);
    chk("R1", 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule